// File: doc/BRIEF.md
# Stop-Mode Power Save Controller

This block holds an 8-bit power save control register and a two-state machine that parks a processor core in a clock-stopped low-power mode. Software enters the mode by setting the stop bit. The machine then drops the core clock enable and waits until a selected interrupt source asks for service. When that happens, it restores the clock and clears the stop bit by itself.

Four mask bits choose which sources may end the mode: three non-maskable request lines, and the maskable requests taken together as one group. A maskable request also counts only when the per-source qualifier from the interrupt controller says the source is not masked. Requests are sampled as levels and never held pending. Register writes are guarded by a one-shot unlock, and writes flagged as coming from DMA are refused.

The machine has two states. In RUN the core clock is enabled. The "enter" transition goes to STOP once the stop bit reads 1. In STOP the core clock is gated. The "wake" transition goes back to RUN when a qualifying request is seen, and it clears the stop bit in the same cycle.

Top module: `pwr_stop_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `core_clk_en` is 1 and `stop_active` is 0.
- R2: Register bits:
    - bit 7 masks NMI line 2 (`nmi_req[2]`);
    - bit 6 masks line 1;
    - bit 5 masks line 0;
    - bit 4 masks the maskable group;
    - bit 1 is the stop request;
    - bits 3, 2 and 0 are not writable and always read 0.
- R3: A write (byte or single-bit) changes the register only when the previous bus access was a `cmd_unlock` pulse with no `bus_other`, write or unlock-consuming access in between. One unlock admits exactly one write.
- R4: A write with `wr_from_dma` = 1 leaves the register unchanged and also consumes any pending unlock.
- R5: A single-bit write acts on bit `wr_bit_idx`:
    - `wr_bit_op` 2'b01 sets the bit;
    - 2'b10 clears it;
    - 2'b11 inverts it;
    - 2'b00 leaves it unchanged.
  The same protection rules as for byte writes apply.
- R6: When the stop bit becomes 1, `stop_active` rises and `core_clk_en` falls on the next clock edge.
- R7: In a write that sets the stop bit, the values written to bits 7..4 are discarded, and the previous mask values stay in effect.
- R8: In STOP, a qualifying request clears the stop bit, sets `core_clk_en` and clears `stop_active` on the next clock edge. A qualifying request is any one of:
    - `nmi_req[i]` with its mask bit 0;
    - `irq_req` with bit 4 = 0 and `irq_src_masked` = 0.
- R9: In STOP, requests from masked sources do not end the mode. Neither does `irq_req` while `irq_src_masked` = 1, even with bit 4 = 0.
- R10: Requests are not latched. A request that is raised and removed while running, or while its mask bit is 1, causes no later wake.
- R11: While the stop bit is 1, register writes are ignored.
- R12: `core_clk_en` is always the inverse of `stop_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_unlock | input | 1 | Write to the unlock command address; arms one register write |
| bus_other | input | 1 | Any other bus access; disarms the unlock |
| wr_byte_en | input | 1 | Byte write strobe to the register |
| wr_byte_data | input | 8 | Byte write data |
| wr_bit_en | input | 1 | Single-bit write strobe |
| wr_bit_idx | input | 3 | Bit index for single-bit write |
| wr_bit_op | input | 2 | Bit operation: 01 set, 10 clear, 11 invert, 00 none |
| wr_from_dma | input | 1 | Write originates from DMA; the write is refused |
| nmi_req | input | 3 | Non-maskable request lines 2..0 |
| irq_req | input | 1 | Combined maskable request |
| irq_src_masked | input | 1 | Per-source mask qualifier for the pending maskable request |
| stop_active | output | 1 | Core is in stop mode |
| core_clk_en | output | 1 | Core clock gate enable |
| rd_data | output | 8 | Register read data |

## Verification
A bad state register shows at the ports in one of two ways:
- `stop_active` and `core_clk_en` disagree with the stop bit in `rd_data` one edge after the stop bit rises;
- the stop bit fails to clear on the same edge that a qualifying request is sampled.

A bad mask register shows as the wrong source waking the core, or the right one failing to wake it, within a single cycle of the request. A mistaken latch on requests shows as a spurious wake on the first edge after entering stop, even though no request line is high. A broken unlock guard shows directly in `rd_data` on the edge after the write.

// File: rtl/pwrstop_pkg.sv
package pwrstop_pkg;
    localparam int REG_W    = 8;
    localparam int NMI_N    = 3;
    localparam int IDX_W    = $clog2(REG_W);
    localparam int STP_POS  = 1;
    localparam int GRP_POS  = 4;
    localparam int NMI_LSB  = 5;
    localparam logic [REG_W-1:0] RW_MASK = 8'hF2;

    typedef enum logic [1:0] {
        BOP_NONE = 2'b00,
        BOP_SET  = 2'b01,
        BOP_CLR  = 2'b10,
        BOP_INV  = 2'b11
    } bit_op_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_STOP = 1'b1
    } pwr_state_e;
endpackage

// File: rtl/pwrstop_guard.sv
module pwrstop_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_unlock,
    input  logic bus_other,
    input  logic wr_any,
    input  logic wr_from_dma,
    input  logic stop_bit,
    output logic wr_accept
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (cmd_unlock) begin
            armed_q <= 1'b1;
        end else if (wr_any || bus_other) begin
            armed_q <= 1'b0;
        end
    end

    assign wr_accept = armed_q && wr_any && !wr_from_dma && !stop_bit;
endmodule

// File: rtl/pwrstop_regfile.sv
module pwrstop_regfile
    import pwrstop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_accept,
    input  logic             wr_byte_en,
    input  logic [REG_W-1:0] wr_byte_data,
    input  logic [IDX_W-1:0] wr_bit_idx,
    input  logic [1:0]       wr_bit_op,
    input  logic             clr_stop,
    output logic [REG_W-1:0] reg_q
);
    logic [REG_W-1:0] cand;
    logic [REG_W-1:0] next_val;

    always_comb begin
        cand = reg_q;
        if (wr_byte_en) begin
            cand = wr_byte_data;
        end else begin
            unique case (bit_op_e'(wr_bit_op))
                BOP_SET:  cand[wr_bit_idx] = 1'b1;
                BOP_CLR:  cand[wr_bit_idx] = 1'b0;
                BOP_INV:  cand[wr_bit_idx] = ~reg_q[wr_bit_idx];
                BOP_NONE: cand = reg_q;
            endcase
        end
        next_val = cand & RW_MASK;
        if (next_val[STP_POS] && !reg_q[STP_POS]) begin
            next_val[REG_W-1:GRP_POS] = reg_q[REG_W-1:GRP_POS];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (clr_stop) begin
            reg_q[STP_POS] <= 1'b0;
        end else if (wr_accept) begin
            reg_q <= next_val;
        end
    end
endmodule

// File: rtl/pwrstop_wake.sv
module pwrstop_wake
    import pwrstop_pkg::*;
(
    input  logic [REG_W-1:0] reg_q,
    input  logic [NMI_N-1:0] nmi_req,
    input  logic             irq_req,
    input  logic             irq_src_masked,
    output logic             wake_req
);
    logic [NMI_N-1:0] nmi_ok;

    for (genvar i = 0; i < NMI_N; i++) begin : g_nmi
        assign nmi_ok[i] = nmi_req[i] && !reg_q[NMI_LSB+i];
    end

    assign wake_req = (|nmi_ok) || (irq_req && !reg_q[GRP_POS] && !irq_src_masked);
endmodule

// File: rtl/pwrstop_fsm.sv
module pwrstop_fsm
    import pwrstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_bit,
    input  logic wake_req,
    output logic stop_active,
    output logic core_clk_en,
    output logic clr_stop
);
    pwr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (stop_bit) state_d = ST_STOP;
            ST_STOP: if (wake_req) state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        stop_active = 1'b0;
        core_clk_en = 1'b1;
        clr_stop    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                stop_active = 1'b0;
                core_clk_en = 1'b1;
            end
            ST_STOP: begin
                stop_active = 1'b1;
                core_clk_en = 1'b0;
                clr_stop    = wake_req;
            end
        endcase
    end
endmodule

// File: rtl/pwr_stop_ctrl.sv
module pwr_stop_ctrl
    import pwrstop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_unlock,
    input  logic             bus_other,
    input  logic             wr_byte_en,
    input  logic [REG_W-1:0] wr_byte_data,
    input  logic             wr_bit_en,
    input  logic [IDX_W-1:0] wr_bit_idx,
    input  logic [1:0]       wr_bit_op,
    input  logic             wr_from_dma,
    input  logic [NMI_N-1:0] nmi_req,
    input  logic             irq_req,
    input  logic             irq_src_masked,
    output logic             stop_active,
    output logic             core_clk_en,
    output logic [REG_W-1:0] rd_data
);
    logic             wr_accept;
    logic             clr_stop;
    logic             wake_req;
    logic [REG_W-1:0] reg_q;

    pwrstop_guard u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_unlock  (cmd_unlock),
        .bus_other   (bus_other),
        .wr_any      (wr_byte_en || wr_bit_en),
        .wr_from_dma (wr_from_dma),
        .stop_bit    (reg_q[STP_POS]),
        .wr_accept   (wr_accept)
    );

    pwrstop_regfile u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_accept    (wr_accept),
        .wr_byte_en   (wr_byte_en),
        .wr_byte_data (wr_byte_data),
        .wr_bit_idx   (wr_bit_idx),
        .wr_bit_op    (wr_bit_op),
        .clr_stop     (clr_stop),
        .reg_q        (reg_q)
    );

    pwrstop_wake u_wake (
        .reg_q          (reg_q),
        .nmi_req        (nmi_req),
        .irq_req        (irq_req),
        .irq_src_masked (irq_src_masked),
        .wake_req       (wake_req)
    );

    pwrstop_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_bit    (reg_q[STP_POS]),
        .wake_req    (wake_req),
        .stop_active (stop_active),
        .core_clk_en (core_clk_en),
        .clr_stop    (clr_stop)
    );

    assign rd_data = reg_q;
endmodule

// File: rtl/pwrstop_chk.sv
module pwrstop_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_byte_en,
    input logic       wr_bit_en,
    input logic       wr_from_dma,
    input logic [2:0] nmi_req,
    input logic       irq_req,
    input logic       irq_src_masked,
    input logic       stop_active,
    input logic       core_clk_en,
    input logic [7:0] rd_data
);
    logic wake_c;
    assign wake_c = (|(nmi_req & ~rd_data[7:5])) ||
                    (irq_req && !rd_data[4] && !irq_src_masked);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3:2] == 2'b00 && !rd_data[0]);

    a_r4_dma_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_en || wr_bit_en) && wr_from_dma && !stop_active |=> $stable(rd_data));

    a_r6_enter_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[1]) |=> (stop_active && !core_clk_en));

    a_r7_masks_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[1]) |-> $stable(rd_data[7:4]));

    a_r8_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
        stop_active && wake_c |=> (!stop_active && core_clk_en && !rd_data[1]));

    a_r9_stay_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        stop_active && !wake_c |=> stop_active);

    a_r11_frozen_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_active && !wake_c |=> $stable(rd_data));

    a_r12_gate_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en != stop_active);
endmodule

bind pwr_stop_ctrl pwrstop_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_byte_en     (wr_byte_en),
    .wr_bit_en      (wr_bit_en),
    .wr_from_dma    (wr_from_dma),
    .nmi_req        (nmi_req),
    .irq_req        (irq_req),
    .irq_src_masked (irq_src_masked),
    .stop_active    (stop_active),
    .core_clk_en    (core_clk_en),
    .rd_data        (rd_data)
);

// File: tb/tb_pwr_stop_ctrl.sv
module tb_pwr_stop_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_unlock = 1'b0, bus_other = 1'b0;
    logic       wr_byte_en = 1'b0, wr_bit_en = 1'b0, wr_from_dma = 1'b0;
    logic [7:0] wr_byte_data = '0;
    logic [2:0] wr_bit_idx = '0;
    logic [1:0] wr_bit_op = '0;
    logic [2:0] nmi_req = '0;
    logic       irq_req = 1'b0, irq_src_masked = 1'b0;
    logic       stop_active, core_clk_en;
    logic [7:0] rd_data;
    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwr_stop_ctrl dut (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_mode(input string tag, input logic stp);
        chk({tag, " stop_active"}, {7'd0, stop_active}, {7'd0, stp});
        chk({tag, " core_clk_en"}, {7'd0, core_clk_en}, {7'd0, !stp});
    endtask

    task automatic unlock();
        cmd_unlock = 1'b1; @(negedge clk); cmd_unlock = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] d, input logic dma);
        wr_byte_en = 1'b1; wr_byte_data = d; wr_from_dma = dma;
        @(negedge clk);
        wr_byte_en = 1'b0; wr_from_dma = 1'b0;
    endtask

    task automatic wbit(input logic [2:0] idx, input logic [1:0] op);
        wr_bit_en = 1'b1; wr_bit_idx = idx; wr_bit_op = op;
        @(negedge clk);
        wr_bit_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset rd", rd_data, 8'h00);
        chk_mode("R1 reset", 1'b0);
    endtask

    task automatic t_protect();
        wbyte(8'hF0, 1'b0);
        chk("R3 unarmed write", rd_data, 8'h00);
        unlock(); bus_other = 1'b1; @(negedge clk); bus_other = 1'b0;
        wbyte(8'hF0, 1'b0);
        chk("R3 disarmed by other access", rd_data, 8'h00);
        unlock(); wbyte(8'hFD, 1'b0);
        chk("R2 reserved bits read zero", rd_data, 8'hF0);
        wbyte(8'h00, 1'b0);
        chk("R3 one write per unlock", rd_data, 8'hF0);
    endtask

    task automatic t_dma();
        unlock(); wbyte(8'h00, 1'b1);
        chk("R4 dma write refused", rd_data, 8'hF0);
        wbyte(8'h00, 1'b0);
        chk("R4 dma consumed unlock", rd_data, 8'hF0);
    endtask

    task automatic t_bitops();
        unlock(); wbit(3'd7, 2'b10);
        chk("R5 bit clear", rd_data, 8'h70);
        unlock(); wbit(3'd4, 2'b11);
        chk("R5 bit invert", rd_data, 8'h60);
        unlock(); wbit(3'd3, 2'b01);
        chk("R5 R2 reserved bit set ignored", rd_data, 8'h60);
        unlock(); wbit(3'd6, 2'b00);
        chk("R5 no-op", rd_data, 8'h60);
        wbit(3'd7, 2'b01);
        chk("R5 unarmed bit write", rd_data, 8'h60);
        unlock(); wbit(3'd7, 2'b01);
        chk("R5 bit set", rd_data, 8'hE0);
    endtask

    task automatic t_stop_irq();
        unlock(); wbyte(8'h12, 1'b0);
        chk("R7 masks kept on stop write", rd_data, 8'hE2);
        chk_mode("R6 before gate", 1'b0);
        @(negedge clk);
        chk_mode("R6 gated", 1'b1);
        unlock(); wbyte(8'h00, 1'b0);
        chk("R11 write ignored in stop", rd_data, 8'hE2);
        unlock(); wbit(3'd1, 2'b10);
        chk("R11 bit write ignored in stop", rd_data, 8'hE2);
        nmi_req = 3'b111; @(negedge clk); nmi_req = 3'b000;
        chk_mode("R9 masked nmi", 1'b1);
        irq_req = 1'b1; irq_src_masked = 1'b1; @(negedge clk);
        irq_req = 1'b0; irq_src_masked = 1'b0;
        chk_mode("R9 qualifier blocks irq", 1'b1);
        @(negedge clk);
        chk_mode("R10 no latched irq", 1'b1);
        irq_req = 1'b1; @(negedge clk); irq_req = 1'b0;
        chk_mode("R8 irq wake", 1'b0);
        chk("R8 stop bit auto-clear", rd_data, 8'hE0);
    endtask

    task automatic t_nolatch_nmi2();
        unlock(); wbyte(8'h70, 1'b0);
        chk("R2 mask write", rd_data, 8'h70);
        nmi_req = 3'b011; irq_req = 1'b1; @(negedge clk);
        nmi_req = 3'b000; irq_req = 1'b0;
        chk_mode("R10 request while running", 1'b0);
        unlock(); wbyte(8'h02, 1'b0);
        chk("R7 zero masks ignored with stop", rd_data, 8'h72);
        @(negedge clk); @(negedge clk);
        chk_mode("R10 no wake from earlier requests", 1'b1);
        nmi_req = 3'b010; @(negedge clk); nmi_req = 3'b000;
        chk_mode("R9 nmi1 masked", 1'b1);
        nmi_req = 3'b100; @(negedge clk); nmi_req = 3'b000;
        chk_mode("R8 nmi2 wake", 1'b0);
        chk("R8 nmi2 clear stop", rd_data, 8'h70);
    endtask

    task automatic t_bitstop_nmi0();
        unlock(); wbyte(8'hD0, 1'b0);
        unlock(); wbit(3'd1, 2'b01);
        chk("R5 bit-set stop", rd_data, 8'hD2);
        @(negedge clk);
        chk_mode("R6 bit-write stop", 1'b1);
        irq_req = 1'b1; @(negedge clk); irq_req = 1'b0;
        chk_mode("R9 group mask blocks irq", 1'b1);
        nmi_req = 3'b001; @(negedge clk); nmi_req = 3'b000;
        chk_mode("R8 nmi0 wake", 1'b0);
        chk("R8 nmi0 clear stop", rd_data, 8'hD0);
        unlock(); wbit(3'd1, 2'b11);
        chk("R5 invert sets stop", rd_data, 8'hD2);
        @(negedge clk);
        chk_mode("R12 gate follows stop", 1'b1);
        nmi_req = 3'b001; @(negedge clk); nmi_req = 3'b000;
        chk_mode("R12 gate restored", 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_protect();
        t_dma();
        t_bitops();
        t_stop_irq();
        t_nolatch_nmi2();
        t_bitstop_nmi0();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule